// File: doc/BRIEF.md
# Sticky Masked Interrupt Latch

This block gathers a word of level interrupt inputs into a sticky status word and raises a single combined interrupt wire while any status bit is set. One input position carries the interrupt line coming up from a downstream host controller. The remaining positions come in on a general input vector and may be tied low.

Software reaches four full-word registers through a plain register port: a sticky status word, an enable mask, a polarity word and a read-only image of the raw inputs. The inputs are sampled into the raw image every cycle. On every cycle, each raw bit that is also enabled in the mask is ORed into status. A status bit then stays set until software writes a one to it. The mask therefore decides what may enter the latch, not what leaves it. The polarity word is kept for software but changes nothing.

Top module: `irq_latch_regs`

## Requirements
- R1: After synchronous reset, all four registers read zero and `irq_out` is low.
- R2: Decode uses byte offsets 0x50 for status, 0x54 for mask, 0x58 for polarity and 0x5C for the raw image. The mask register accepts a full 32-bit write and reads back the same value.
- R3: The polarity register stores and reads back any 32-bit value. Its contents never alter latching or `irq_out`.
- R4: The raw image samples its inputs on every clock edge. Bit 11 (0x00000800) shows `hc_irq` ORed with `aux_irq[11]`, and every other bit shows its `aux_irq` bit. Writes to offset 0x5C have no effect.
- R5: A status bit is set on the clock edge after the matching raw bit and mask bit are both one. It stays set after the input falls.
- R6: A raw bit whose mask bit is zero never sets status. Clearing a mask bit later does not clear a status bit that is already latched.
- R7: A write to status clears each bit written as one and leaves each bit written as zero unchanged.
- R8: If the raw bit and mask bit of a status bit are still both one when software clears it, the bit is set again on that same edge and reads back as one.
- R9: `irq_out` is high exactly while at least one status bit is set.
- R10: A read of any other offset, misaligned ones included, returns 0xFFFFFFFF. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 8 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| hc_irq | input | 1 | Host-controller interrupt level |
| aux_irq | input | 32 | Other interrupt levels, may be tied low |
| irq_out | output | 1 | Combined interrupt, high while status is non-zero |

## Verification
The bench targets the order of effects between mask and status. It latches a source, then drops the mask, and expects the bit to survive. A design that gated the output instead of the latch entry would drop `irq_out` at that point. It also clears a bit whose source is still active, and the bit must re-latch. A design that let the clear win would lose a live interrupt. Other tests cover a write-zero status pattern, a write to the raw image, writes to misaligned and unmapped offsets, and an all-ones polarity word. A wrong decode, a stored raw write, or an input inversion in any of these would show up as changed read data or a changed output.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
   localparam int REG_COUNT  = 4;
   localparam int WORD_BYTES = 4;

   typedef enum logic [1:0] {
      REG_STAT = 2'd0,
      REG_MASK = 2'd1,
      REG_POL  = 2'd2,
      REG_RAW  = 2'd3
   } reg_idx_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode #(
   parameter int ADDR_W   = 8,
   parameter int BASE_OFF = 'h50
) (
   input  logic [ADDR_W-1:0]                     addr,
   output logic [irq_latch_pkg::REG_COUNT-1:0]   sel
);
   import irq_latch_pkg::*;

   for (genvar i = 0; i < REG_COUNT; i++) begin : g_sel
      localparam int OFF = BASE_OFF + i * WORD_BYTES;
      assign sel[i] = (addr == OFF[ADDR_W-1:0]);
   end
endmodule

// File: rtl/irq_raw_sampler.sv
module irq_raw_sampler #(
   parameter int DATA_W      = 32,
   parameter int HC_BIT      = 11,
   parameter int SYNC_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hc_irq,
   input  logic [DATA_W-1:0] aux_irq,
   output logic [DATA_W-1:0] raw_q
);
   logic [DATA_W-1:0] merged;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == HC_BIT) begin : g_hc
         assign merged[b] = hc_irq | aux_irq[b];
      end else begin : g_aux
         assign merged[b] = aux_irq[b];
      end
   end

   if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
         if (rst) raw_q <= '0;
         else     raw_q <= merged;
      end
   end else begin : g_chain
      logic [DATA_W-1:0] stage_q [SYNC_STAGES];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
         end else begin
            stage_q[0] <= merged;
            for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign raw_q = stage_q[SYNC_STAGES-1];
   end
endmodule

// File: rtl/irq_sticky_core.sv
module irq_sticky_core #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_stat,
   input  logic              wr_mask,
   input  logic              wr_pol,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] raw_q,
   output logic [DATA_W-1:0] status_q,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] pol_q
);
   logic [DATA_W-1:0] clr_bits;
   logic [DATA_W-1:0] set_bits;
   logic [DATA_W-1:0] status_d;

   always_comb begin
      clr_bits = wr_stat ? wdata : '0;
      set_bits = raw_q & mask_q;
      status_d = (status_q & ~clr_bits) | set_bits;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         status_q <= '0;
         mask_q   <= '0;
         pol_q    <= '0;
      end else begin
         status_q <= status_d;
         if (wr_mask) mask_q <= wdata;
         if (wr_pol)  pol_q  <= wdata;
      end
   end
endmodule

// File: rtl/irq_latch_regs.sv
module irq_latch_regs #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int BASE_OFF    = 'h50,
   parameter int HC_BIT      = 11,
   parameter int SYNC_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              hc_irq,
   input  logic [DATA_W-1:0] aux_irq,
   output logic              irq_out
);
   import irq_latch_pkg::*;

   localparam int LAST_OFF = BASE_OFF + (REG_COUNT - 1) * WORD_BYTES;

   if (HC_BIT >= DATA_W) begin : g_bad_hc
      $error("HC_BIT must lie inside the data word");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("SYNC_STAGES must be 1 to 3");
   end
   if (LAST_OFF >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register window does not fit the address width");
   end
   if (BASE_OFF % WORD_BYTES != 0) begin : g_bad_align
      $error("BASE_OFF must be word aligned");
   end

   logic [REG_COUNT-1:0] reg_sel;
   logic [DATA_W-1:0]    raw_q;
   logic [DATA_W-1:0]    status_q;
   logic [DATA_W-1:0]    mask_q;
   logic [DATA_W-1:0]    pol_q;

   irq_addr_decode #(.ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)) u_dec (
      .addr (addr),
      .sel  (reg_sel)
   );

   irq_raw_sampler #(.DATA_W(DATA_W), .HC_BIT(HC_BIT),
                     .SYNC_STAGES(SYNC_STAGES)) u_raw (
      .clk     (clk),
      .rst     (rst),
      .hc_irq  (hc_irq),
      .aux_irq (aux_irq),
      .raw_q   (raw_q)
   );

   irq_sticky_core #(.DATA_W(DATA_W)) u_core (
      .clk      (clk),
      .rst      (rst),
      .wr_stat  (wr_en && reg_sel[REG_STAT]),
      .wr_mask  (wr_en && reg_sel[REG_MASK]),
      .wr_pol   (wr_en && reg_sel[REG_POL]),
      .wdata    (wdata),
      .raw_q    (raw_q),
      .status_q (status_q),
      .mask_q   (mask_q),
      .pol_q    (pol_q)
   );

   always_comb begin
      unique case (1'b1)
         reg_sel[REG_STAT]: rdata = status_q;
         reg_sel[REG_MASK]: rdata = mask_q;
         reg_sel[REG_POL]:  rdata = pol_q;
         reg_sel[REG_RAW]:  rdata = raw_q;
         default:           rdata = '1;
      endcase
   end

   assign irq_out = |status_q;
endmodule

// File: rtl/irq_latch_checker.sv
module irq_latch_checker #(
   parameter int DATA_W      = 32,
   parameter int HC_BIT      = 11,
   parameter int SYNC_STAGES = 1
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [3:0]        reg_sel,
   input logic              hc_irq,
   input logic [DATA_W-1:0] raw_q,
   input logic [DATA_W-1:0] status_q,
   input logic [DATA_W-1:0] mask_q,
   input logic [DATA_W-1:0] pol_q,
   input logic              irq_out
);
   // R5: with no status write, latched bits are kept
   assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      !$past(wr_en && reg_sel[0]) |->
         ((status_q & $past(status_q)) == $past(status_q)));

   // R6: a newly set status bit needs raw and mask both set one cycle before
   assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
      (status_q & ~$past(status_q) & ~$past(raw_q & mask_q)) == '0);

   // R9: the output only rises after an enabled raw bit was seen
   assert_rise_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_out) |-> $past(|(raw_q & mask_q)));

   // R3: polarity changes only through its own write
   assert_pol_R3: assert property (@(posedge clk) disable iff (rst)
      !$past(wr_en && reg_sel[2]) |-> $stable(pol_q));

   // R4: host line appears in the raw image one edge later
   if (SYNC_STAGES == 1) begin : g_raw_chk
      assert_raw_R4: assert property (@(posedge clk) disable iff (rst)
         $past(hc_irq) |-> raw_q[HC_BIT]);
   end
endmodule

bind irq_latch_regs irq_latch_checker #(
   .DATA_W(DATA_W), .HC_BIT(HC_BIT), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wr_en    (wr_en),
   .reg_sel  (reg_sel),
   .hc_irq   (hc_irq),
   .raw_q    (raw_q),
   .status_q (status_q),
   .mask_q   (mask_q),
   .pol_q    (pol_q),
   .irq_out  (irq_out)
);

// File: tb/irq_latch_regs_test.sv
module irq_latch_regs_test;
   localparam logic [7:0] A_STAT = 8'h50;
   localparam logic [7:0] A_MASK = 8'h54;
   localparam logic [7:0] A_POL  = 8'h58;
   localparam logic [7:0] A_RAW  = 8'h5C;
   localparam logic [31:0] HCB   = 32'h0000_0800;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        hc_irq = 1'b0;
   logic [31:0] aux_irq = '0;
   logic        irq_out;
   int total = 0;
   int bad = 0;

   irq_latch_regs uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .hc_irq(hc_irq), .aux_irq(aux_irq), .irq_out(irq_out)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = 8'h00; wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
      addr = 8'h00;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_STAT, v); chk("R1 status", v, 0);
      rd(A_MASK, v); chk("R1 mask", v, 0);
      rd(A_POL, v);  chk("R1 pol", v, 0);
      rd(A_RAW, v);  chk("R1 raw", v, 0);
      chk("R1 irq", {31'b0, irq_out}, 0);
   endtask

   task automatic t_decode();
      logic [31:0] v;
      wr(A_MASK, 32'hA5C3_0F12);
      rd(A_MASK, v); chk("R2 mask rb", v, 32'hA5C3_0F12);
      wr(A_POL, 32'h1234_5678);
      rd(A_POL, v); chk("R3 pol rb", v, 32'h1234_5678);
      wr(A_RAW, 32'hFFFF_FFFF);
      rd(A_RAW, v); chk("R4 raw write ignored", v, 0);
      rd(8'h60, v); chk("R10 unmapped read", v, 32'hFFFF_FFFF);
      rd(8'h55, v); chk("R10 misaligned read", v, 32'hFFFF_FFFF);
      wr(8'h56, 32'h0);
      wr(8'h4C, 32'h0);
      rd(A_MASK, v); chk("R10 stray write no effect", v, 32'hA5C3_0F12);
      wr(A_MASK, 0);
      wr(A_POL, 0);
   endtask

   task automatic t_latch();
      logic [31:0] v;
      wr(A_MASK, HCB);
      hc_irq = 1'b1;
      tick(1);
      rd(A_RAW, v); chk("R4 raw hc bit", v, HCB);
      rd(A_STAT, v); chk("R5 not yet latched", v, 0);
      tick(1);
      rd(A_STAT, v); chk("R5 latched", v, HCB);
      chk("R9 irq high", {31'b0, irq_out}, 1);
      hc_irq = 1'b0;
      tick(3);
      rd(A_STAT, v); chk("R5 sticky after drop", v, HCB);
      wr(A_MASK, 0);
      tick(1);
      rd(A_STAT, v); chk("R6 mask clear keeps bit", v, HCB);
      chk("R6 irq still high", {31'b0, irq_out}, 1);
      wr(A_STAT, 0);
      rd(A_STAT, v); chk("R7 write zero keeps", v, HCB);
      wr(A_STAT, HCB);
      rd(A_STAT, v); chk("R7 write one clears", v, 0);
      chk("R9 irq low", {31'b0, irq_out}, 0);
   endtask

   task automatic t_gate();
      logic [31:0] v;
      wr(A_MASK, 32'h0000_0001);
      aux_irq = 32'h0000_0005;
      tick(3);
      rd(A_RAW, v);  chk("R4 aux bits", v, 32'h0000_0005);
      rd(A_STAT, v); chk("R6 only enabled bit", v, 32'h0000_0001);
      wr(A_STAT, 32'h0000_0001);
      rd(A_STAT, v); chk("R8 relatch while active", v, 32'h0000_0001);
      aux_irq = '0;
      tick(2);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, v); chk("R7 cleared after drop", v, 0);
      wr(A_MASK, 0);
   endtask

   task automatic t_polarity();
      logic [31:0] v;
      wr(A_POL, 32'hFFFF_FFFF);
      wr(A_MASK, HCB);
      tick(3);
      rd(A_STAT, v); chk("R3 no inversion of low input", v, 0);
      chk("R3 irq stays low", {31'b0, irq_out}, 0);
      hc_irq = 1'b1;
      tick(2);
      rd(A_STAT, v); chk("R3 high input latches", v, HCB);
      hc_irq = 1'b0;
      tick(2);
      wr(A_STAT, HCB);
      chk("R9 irq low after clear", {31'b0, irq_out}, 0);
   endtask

   initial begin : watchdog
      #500us;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(3);
      rst = 1'b0;
      t_reset();
      t_decode();
      t_latch();
      t_gate();
      t_polarity();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule